// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Completion-Flag Handshake

This block moves one byte at a time over a four-wire serial link and is reached by a CPU through a small register bus: a control register, a status register and a data register. As master it makes the serial clock itself from the system clock by a fixed divide-by-4. It drives `sck_out` and `mosi_out` and samples `miso_in`. As slave it takes the serial clock, data and select from an external master on `sck_in`, `mosi_in` and `ss_n`, and shifts its own byte out on `miso_out`. Clock idle level and sampling edge can be set, and both modes support them.

When a byte completes, the block sets a completion flag. At the same moment it latches the received byte, and it can raise an interrupt. Software clears the flag with a two-step handshake: first it touches the status register while the flag is set, then it accesses the data register. Until the first step has happened, writes to the data register are dropped. This keeps the CPU from overwriting the shift register before it has seen that a byte finished.

Top module: `spi_flag_port`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, `irq` is 0, `pins_en` is 0 and `sck_out` is 0.
- R2: Register map on `bus_addr`: 0 is control (bit 0 enable, bit 1 master, bit 2 clock idle level CPOL, bit 3 phase CPHA, bit 4 interrupt enable). 1 is status (bit 7 completion flag, other bits 0). 2 is data (a write loads the transmit byte, a read returns the last received byte). 3 reads 0. `bus_rdata` is combinational on `bus_addr`.
- R3: In master mode, an accepted data write starts a transfer of 16 SCK edges, one edge every 2 system clocks. The byte goes out on `mosi_out` MSB first, and `miso_in` is shifted in MSB first.
- R4: SCK idles at CPOL. With CPHA=0, data is sampled on the leading edge and changed on the trailing edge. With CPHA=1 it is changed on the leading edge and sampled on the trailing edge.
- R5: At completion, the flag (status bit 7) sets and the received byte becomes readable at data in the same cycle.
- R6: `irq` is 1 exactly when the flag is set, interrupt enable is 1 and `irq_mask` is 0.
- R7: The flag clears only after an access (read or write) to status while it is set, followed by a data-register access. In master mode that access must be a read. In slave mode a read or a write completes the clear. A data read before the status access does not clear the flag.
- R8: While the flag is set and status has not been accessed since, a data write is ignored: no transfer starts and the shift register is unchanged.
- R9: Slave mode is control enable=1 with master=0. While `ss_n` is low, the block follows `sck_in`, shifts its byte out MSB first on `miso_out` and shifts `mosi_in` in MSB first. The inputs pass through two-stage synchronisers first.
- R10: In slave mode with CPHA=0, a data write while `ss_n` is low is ignored. The slave then sends its previous shift register contents, which is the last received byte.
- R11: In slave mode with CPHA=1, `ss_n` may stay low across bytes. A data write accepted between bytes both clears the pending flag and loads the next byte.
- R12: With enable=0, data writes are ignored, `pins_en`, `mosi_out` and `miso_out` are 0 and `sck_out` rests at CPOL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_mask | input | 1 | CPU-side interrupt mask |
| irq | output | 1 | Interrupt request |
| pins_en | output | 1 | Serial pin functions active |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| sck_in | input | 1 | Serial clock from an external master |
| mosi_in | input | 1 | Serial data in for slave mode |
| ss_n | input | 1 | Slave select, active low |
| miso_out | output | 1 | Serial data out in slave mode |

## Verification
The assertions assume at most one bus access per cycle. They also assume that control is not rewritten while a master byte is in flight, since the SCK pacing check follows only a running transfer. In slave mode, correct sampling depends on each level of `sck_in`, `mosi_in` and `ss_n` lasting longer than the synchroniser delay. The bench therefore holds every slave-side level for four system clocks and changes `mosi_in` a full phase away from the edge that samples it. It also writes control only while the block is idle.

// File: rtl/spi_flag_port.sv
module spi_flag_port #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_mask,
  output logic          irq,
  output logic          pins_en,
  output logic          sck_out,
  output logic          mosi_out,
  input  logic          miso_in,
  input  logic          sck_in,
  input  logic          mosi_in,
  input  logic          ss_n,
  output logic          miso_out
);
  localparam int CW = $clog2(DW);
  localparam int EW = CW + 1;
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [4:0]    ctrl;
  logic          flag, armed, busy, sck_q, txb;
  logic [DW-1:0] shreg, rxbuf;
  logic [CW-1:0] bitcnt;
  logic [EW-1:0] edges;
  logic [HW-1:0] div;
  logic [2:0]    sck_s;
  logic [1:0]    mosi_s, ss_s;

  logic en, mst, cpol, cpha, ie;
  assign en   = ctrl[0];
  assign mst  = ctrl[1];
  assign cpol = ctrl[2];
  assign cpha = ctrl[3];
  assign ie   = ctrl[4];

  logic acc_ctl, acc_sts, acc_dat;
  assign acc_ctl = bus_addr == 2'd0;
  assign acc_sts = bus_addr == 2'd1;
  assign acc_dat = bus_addr == 2'd2;

  logic tick, m_samp, m_shift, m_done;
  assign tick    = mst && busy && (div == HW'(HALF - 1));
  assign m_samp  = tick && (edges[0] == cpha);
  assign m_shift = tick && (edges[0] != cpha);
  assign m_done  = tick && (edges == EW'(2 * DW - 1));

  logic s_act, s_edge, s_lead, s_samp, s_shift;
  assign s_act   = en && !mst && !ss_s[1];
  assign s_edge  = s_act && (sck_s[1] ^ sck_s[2]);
  assign s_lead  = sck_s[1] != cpol;
  assign s_samp  = s_edge && (s_lead ^ cpha);
  assign s_shift = s_edge && !(s_lead ^ cpha);

  logic samp, shift, done, rx_bit, load_ok, dat_wr, clr;
  logic [DW-1:0] sh_nx;
  assign samp    = mst ? m_samp  : s_samp;
  assign shift   = mst ? m_shift : s_shift;
  assign done    = mst ? m_done  : (s_samp && bitcnt == CW'(DW - 1));
  assign rx_bit  = mst ? miso_in : mosi_s[1];
  assign sh_nx   = {shreg[DW-2:0], rx_bit};
  assign load_ok = mst ? !busy : (cpha ? (bitcnt == '0) : ss_s[1]);
  assign dat_wr  = bus_wr && acc_dat && en && (!flag || armed) && load_ok;
  assign clr     = armed && flag && acc_dat && (bus_rd || (bus_wr && !mst));

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(DW-5){1'b0}}, ctrl};
      2'd1:    bus_rdata = {flag, {(DW-1){1'b0}}};
      2'd2:    bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq      = flag && ie && !irq_mask;
  assign pins_en  = en;
  assign sck_out  = (en && mst && busy) ? sck_q : cpol;
  assign mosi_out = (en && mst) ? txb : 1'b0;
  assign miso_out = s_act ? txb : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      flag   <= 1'b0;
      armed  <= 1'b0;
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      txb    <= 1'b0;
      shreg  <= '0;
      rxbuf  <= '0;
      bitcnt <= '0;
      edges  <= '0;
      div    <= '0;
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= 2'b11;
    end else begin
      sck_s  <= {sck_s[1:0], sck_in};
      mosi_s <= {mosi_s[0], mosi_in};
      ss_s   <= {ss_s[0], ss_n};

      if (bus_wr && acc_ctl) ctrl <= bus_wdata[4:0];

      if (samp) begin
        shreg  <= sh_nx;
        bitcnt <= bitcnt + 1'b1;
      end
      if (shift) txb <= shreg[DW-1];
      if (!mst && ss_s[1]) bitcnt <= '0;

      if (busy) div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        sck_q <= ~sck_q;
        edges <= edges + 1'b1;
      end
      if (m_done || !en) busy <= 1'b0;

      if (dat_wr) begin
        shreg  <= bus_wdata;
        txb    <= bus_wdata[DW-1];
        bitcnt <= '0;
        if (mst) begin
          busy  <= 1'b1;
          edges <= '0;
          div   <= '0;
          sck_q <= cpol;
        end
      end

      if (done) begin
        rxbuf <= samp ? sh_nx : shreg;
        flag  <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end

      if (done || clr)                                    armed <= 1'b0;
      else if (flag && acc_sts && (bus_rd || bus_wr))     armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_flag_port_chk.sv
module spi_flag_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       flag,
  input logic       armed,
  input logic       busy,
  input logic       mst,
  input logic       cpol,
  input logic       sck_q,
  input logic       sck_out,
  input logic       bus_wr,
  input logic [1:0] bus_addr
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag); // R5
  AST_CLEAR_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed)); // R7
  AST_WRITE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && flag && !armed && !busy && bus_wr && bus_addr == 2'd2) |=> !busy); // R8
  AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck_out != $past(sck_out)) |=> sck_out == $past(sck_out)); // R3
  AST_SCK_PARKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mst) |-> sck_q == cpol); // R4
endmodule

bind spi_flag_port spi_flag_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .flag(flag), .armed(armed),
  .busy(busy), .mst(mst), .cpol(cpol), .sck_q(sck_q), .sck_out(sck_out),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/tb_spi_flag_port.sv
module tb_spi_flag_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq_mask = 1'b0, irq, pins_en;
  logic       sck_out, mosi_out, miso_in = 1'b0;
  logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1, miso_out;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit ie, cpha, cpol, m, en);
    return {3'b0, ie, cpha, cpol, m, en};
  endfunction

  // bench acts as the far-end slave; returns the byte seen on mosi_out
  task automatic master_xfer(input bit cpol, cpha, input logic [7:0] tx, rxs, input bit clear);
    logic [7:0] got, v;
    int n, gap, badgap;
    logic prev;
    wr(2'd0, ctl(1, cpha, cpol, 1, 1));
    chk("R4 idle level", sck_out, cpol);
    miso_in = cpha ? 1'b0 : rxs[7];
    wr(2'd2, tx);
    prev = sck_out; n = 0; gap = 0; badgap = 0; got = '0;
    while (n < 16) begin
      @(negedge clk);
      gap++;
      if (sck_out !== prev) begin
        if (n > 0 && gap != 2) badgap++;
        gap = 0;
        prev = sck_out;
        if ((n % 2) == int'(cpha)) got[7 - n/2] = mosi_out;
        else begin
          int k;
          k = cpha ? n/2 : (n+1)/2;
          if (k < 8) miso_in = rxs[7-k];
        end
        n++;
      end
    end
    chk("R3 edge every 2 clocks", badgap, 0);
    chk("R3 mosi byte", got, tx);
    chk("R6 irq on completion", irq, 1'b1);
    chk("R4 sck back to idle", sck_out, cpol);
    if (clear) begin
      rd(2'd1, v); chk("R5 flag set", v, 8'h80);
      rd(2'd2, v); chk("R5 received byte", v, rxs);
      rd(2'd1, v); chk("R7 flag cleared", v, 8'h00);
      chk("R6 irq dropped", irq, 1'b0);
    end
  endtask

  task automatic slave_byte(input bit cpol, cpha, input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int k = 0; k < 8; k++) begin
      if (!cpha) begin
        mosi_in = mo[7-k]; hold(4);
        mi[7-k] = miso_out; sck_in = ~cpol; hold(4);
        sck_in = cpol; hold(4);
      end else begin
        sck_in = ~cpol; hold(4);
        mosi_in = mo[7-k]; hold(4);
        mi[7-k] = miso_out; sck_in = cpol; hold(4);
      end
    end
  endtask

  task automatic slave_xfer(input bit cpol, input logic [7:0] tx, mo);
    logic [7:0] mi, v;
    wr(2'd0, ctl(1, 0, cpol, 0, 1));
    sck_in = cpol; ss_n = 1'b1; hold(4);
    wr(2'd2, tx);
    ss_n = 1'b0; hold(4);
    slave_byte(cpol, 1'b0, mo, mi);
    ss_n = 1'b1; hold(6);
    chk("R9 miso byte", mi, tx);
    chk("R5 slave irq", irq, 1'b1);
    rd(2'd1, v); chk("R5 slave flag", v, 8'h80);
    rd(2'd2, v); chk("R9 slave rx byte", v, mo);
    rd(2'd1, v); chk("R7 slave clear by read", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, mi;
    logic prev;
    int toggles;
    void'($urandom(32'd2024));
    hold(3);
    rst_n = 1'b1;
    hold(1);

    rd(2'd0, v); chk("R1 control reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 pins_en reset", pins_en, 1'b0);
    chk("R1 sck reset", sck_out, 1'b0);
    rd(2'd3, v); chk("R2 unused address", v, 8'h00);

    // R12: disabled block ignores data writes
    wr(2'd0, ctl(0, 0, 1, 1, 0));
    wr(2'd2, 8'h3C);
    prev = sck_out; toggles = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (sck_out !== prev) toggles++;
    end
    chk("R12 no clock when disabled", toggles, 0);
    chk("R12 sck rests at cpol", sck_out, 1'b1);
    chk("R12 pins_en low", pins_en, 1'b0);
    chk("R12 mosi low", mosi_out, 1'b0);
    rd(2'd0, v); chk("R2 control readback", v, 8'h06);

    // directed master corners, all four modes
    master_xfer(0, 0, 8'hA5, 8'h3C, 1);
    master_xfer(0, 1, 8'h80, 8'h01, 1);
    master_xfer(1, 0, 8'h01, 8'hFE, 1);
    master_xfer(1, 1, 8'hFF, 8'h00, 1);

    // flag left pending: mask, inhibit, clear order
    master_xfer(0, 0, 8'h5A, 8'hC3, 0);
    irq_mask = 1'b1; #1 chk("R6 masked irq", irq, 1'b0);
    @(negedge clk); irq_mask = 1'b0; #1 chk("R6 unmasked irq", irq, 1'b1);
    @(negedge clk);
    wr(2'd0, ctl(0, 0, 0, 1, 1)); #1 chk("R6 irq needs enable", irq, 1'b0);
    @(negedge clk);
    wr(2'd2, 8'hF0);
    prev = sck_out; toggles = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (sck_out !== prev) toggles++;
    end
    chk("R8 write blocked while flag set", toggles, 0);
    rd(2'd2, v); chk("R8 rx byte kept", v, 8'hC3);
    rd(2'd1, v); chk("R7 data read first does not clear", v, 8'h80);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 status then data clears", v, 8'h00);

    // random master traffic
    for (int i = 0; i < 8; i++) begin
      logic [31:0] r;
      r = $urandom();
      master_xfer(r[16], r[17], r[7:0], r[15:8], 1);
    end

    // slave CPHA=0 directed and random
    slave_xfer(0, 8'hC9, 8'h6D);
    slave_xfer(1, 8'h81, 8'h7E);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] r;
      r = $urandom();
      slave_xfer(r[16], r[7:0], r[15:8]);
    end

    // R10: write while ss_n low is ignored in CPHA=0 slave
    wr(2'd0, ctl(1, 0, 0, 0, 1));
    sck_in = 1'b0;
    wr(2'd2, 8'h11);
    ss_n = 1'b1; hold(4);
    ss_n = 1'b0; hold(4);
    slave_byte(0, 0, 8'hB4, mi);
    ss_n = 1'b1; hold(6);
    chk("R10 first byte out", mi, 8'h11);
    rd(2'd1, v); rd(2'd2, v); chk("R10 first byte in", v, 8'hB4);
    ss_n = 1'b0; hold(4);
    wr(2'd2, 8'h99);
    slave_byte(0, 0, 8'h2E, mi);
    ss_n = 1'b1; hold(6);
    chk("R10 write with ss low ignored", mi, 8'hB4);
    rd(2'd1, v); rd(2'd2, v); chk("R10 rx after ignored write", v, 8'h2E);

    // R11: CPHA=1 slave, ss_n low across two bytes, clear by write
    wr(2'd0, ctl(1, 1, 1, 0, 1));
    sck_in = 1'b1; ss_n = 1'b1; hold(4);
    wr(2'd2, 8'h4B);
    ss_n = 1'b0; hold(4);
    slave_byte(1, 1, 8'hE2, mi);
    hold(6);
    chk("R11 byte one out", mi, 8'h4B);
    chk("R11 flag raised", irq, 1'b1);
    rd(2'd1, v);
    wr(2'd2, 8'hD7);
    rd(2'd1, v); chk("R11 slave write clears flag", v, 8'h00);
    rd(2'd2, v); chk("R11 byte one in", v, 8'hE2);
    slave_byte(1, 1, 8'h3A, mi);
    hold(6);
    chk("R11 byte two out", mi, 8'hD7);
    rd(2'd1, v); chk("R11 flag again", v, 8'h80);
    rd(2'd2, v); chk("R11 byte two in", v, 8'h3A);
    rd(2'd1, v); chk("R7 cleared after byte two", v, 8'h00);
    ss_n = 1'b1; hold(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule